// File: doc/BRIEF.md
# Short-branch shadow squash unit

This unit serves a two-lane in-order pipeline. When an issue group holds a conditional branch in lane 0 whose target lies just past the instruction beside it in lane 1, the two are bound together as a pair. They are not merged. Each keeps its own lane and both advance through the stages side by side. The lane 1 instruction always executes. Only its architectural effects are withheld when the branch is resolved taken at the last stage.

Nothing is predicted and nothing is flushed for such a pair. At the final stage the resolved outcome gates the lane 1 register write, store and exception report. A taken branch cancels all three. A not-taken branch lets the instruction commit as usual. Groups that do not fit the pattern pass through unchanged and leave branch handling to the normal path. A stall freezes every stage. A flush from an older instruction empties every stage.

Top module: `short_branch_squash`

## Requirements
- R1: A group is paired only when lane 0 is a valid conditional branch, lane 1 is a valid non-branch, and the lane 0 offset equals the byte size of lane 0 plus that of lane 1. An instruction is 2 bytes when its compressed flag is 1 and 4 bytes otherwise, so the offset is 8, 6 or 4.
- R2: A group that fails the R1 test is not paired. For such a group, `br_taken` has no effect on any lane 1 output.
- R3: A group accepted at a rising edge with no stall or flush reaches the final stage after DEPTH rising edges (3 by default), with both lanes present in the same cycle.
- R4: For a paired group in the final stage with `br_taken` high, `l1_wb_en`, `l1_st_en` and `l1_exc` are 0 and `l1_cancel` is 1.
- R5: For a paired group in the final stage with `br_taken` low, the lane 1 enables follow its own write, store and fault flags, and `l1_cancel` is 0.
- R6: Lane 0 enables follow lane 0's own flags whatever the pairing and the branch outcome.
- R7: While `stall` is high, no enable or cancel output is asserted and no stage changes. A held pair keeps its pairing and resumes once the stall drops.
- R8: While `flush` is high, no enable or cancel output is asserted, and every group in flight is discarded. Flush wins over stall.
- R9: After reset every stage is empty and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold all stages |
| flush | input | 1 | Kill all in-flight groups |
| a_vld | input | 1 | Lane 0 instruction valid |
| a_is_br | input | 1 | Lane 0 is a conditional branch |
| a_is_c | input | 1 | Lane 0 is 2 bytes (else 4) |
| a_off | input | OFF_W | Lane 0 branch byte offset |
| a_wr | input | 1 | Lane 0 writes a register |
| a_st | input | 1 | Lane 0 is a store |
| a_fault | input | 1 | Lane 0 raised an exception |
| b_vld | input | 1 | Lane 1 instruction valid |
| b_is_br | input | 1 | Lane 1 is a conditional branch |
| b_is_c | input | 1 | Lane 1 is 2 bytes (else 4) |
| b_off | input | OFF_W | Lane 1 branch byte offset (unused by pairing) |
| b_wr | input | 1 | Lane 1 writes a register |
| b_st | input | 1 | Lane 1 is a store |
| b_fault | input | 1 | Lane 1 raised an exception |
| br_taken | input | 1 | Resolved outcome of the lane 0 branch in the final stage |
| l0_wb_en | output | 1 | Lane 0 register write enable |
| l0_st_en | output | 1 | Lane 0 store enable |
| l0_exc | output | 1 | Lane 0 exception report |
| l1_wb_en | output | 1 | Lane 1 register write enable |
| l1_st_en | output | 1 | Lane 1 store enable |
| l1_exc | output | 1 | Lane 1 exception report |
| l1_cancel | output | 1 | Lane 1 effects cancelled this cycle |

## Verification
The pairing flag travels with the group, and its only visible trace is whether `br_taken` silences lane 1 DEPTH cycles after issue. A wrongly set or lost flag therefore shows up as a spurious or missing cancel on the exact cycle the group reaches the final stage. A stage register that slips under stall or survives a flush shows up as a group arriving one cycle early or late, arriving twice, or arriving at all after a flush. The bench times each check to the cycle so that these shifts are caught.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    parameter int OFF_W      = 13;
    localparam int BYTES_FULL = 4;
    localparam int BYTES_HALF = 2;

    typedef struct packed {
        logic             vld;
        logic             is_br;
        logic             is_c;
        logic [OFF_W-1:0] off;
        logic             wr;
        logic             st;
        logic             fault;
    } insn_t;

    typedef struct packed {
        logic vld;
        logic wr;
        logic st;
        logic fault;
    } slot_t;

    typedef struct packed {
        slot_t l0;
        slot_t l1;
        logic  paired;
    } stage_t;

    function automatic logic [OFF_W-1:0] insn_bytes(input logic is_c);
        return is_c ? OFF_W'(BYTES_HALF) : OFF_W'(BYTES_FULL);
    endfunction

    function automatic slot_t to_slot(input insn_t i);
        slot_t s;
        s.vld   = i.vld;
        s.wr    = i.wr;
        s.st    = i.st;
        s.fault = i.fault;
        return s;
    endfunction
endpackage

// File: rtl/ssq_pair_detect.sv
module ssq_pair_detect
    import ssq_pkg::*;
(
    input  insn_t a,
    input  insn_t b,
    output logic  paired
);
    logic [OFF_W-1:0] span;
    always_comb begin
        span   = insn_bytes(a.is_c) + insn_bytes(b.is_c);
        paired = a.vld && a.is_br && b.vld && !b.is_br && (a.off == span);
    end
endmodule

// File: rtl/ssq_pipe.sv
module ssq_pipe
    import ssq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  logic   flush,
    input  stage_t in_stage,
    output stage_t fin
);
    localparam int LAST = DEPTH - 1;
    stage_t q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < DEPTH; s++) q[s] <= '0;
        end else if (!stall) begin
            q[0] <= in_stage;
            for (int s = 1; s < DEPTH; s++) q[s] <= q[s-1];
        end
    end

    assign fin = q[LAST];

    // R7: a stall without flush freezes the final stage
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> $stable(fin));
    // R8: a flush leaves the final stage empty
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!fin.l0.vld && !fin.l1.vld && !fin.paired));
endmodule

// File: rtl/ssq_commit_gate.sv
module ssq_commit_gate
    import ssq_pkg::*;
(
    input  stage_t fin,
    input  logic   stall,
    input  logic   flush,
    input  logic   br_taken,
    output logic   l0_wb_en,
    output logic   l0_st_en,
    output logic   l0_exc,
    output logic   l1_wb_en,
    output logic   l1_st_en,
    output logic   l1_exc,
    output logic   l1_cancel
);
    logic go, kill1;
    always_comb begin
        go        = !stall && !flush;
        kill1     = fin.paired && br_taken;
        l0_wb_en  = go && fin.l0.vld && fin.l0.wr;
        l0_st_en  = go && fin.l0.vld && fin.l0.st;
        l0_exc    = go && fin.l0.vld && fin.l0.fault;
        l1_wb_en  = go && fin.l1.vld && fin.l1.wr    && !kill1;
        l1_st_en  = go && fin.l1.vld && fin.l1.st    && !kill1;
        l1_exc    = go && fin.l1.vld && fin.l1.fault && !kill1;
        l1_cancel = go && fin.l1.vld && kill1;
    end
endmodule

// File: rtl/short_branch_squash.sv
module short_branch_squash
    import ssq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             flush,
    input  logic             a_vld,
    input  logic             a_is_br,
    input  logic             a_is_c,
    input  logic [OFF_W-1:0] a_off,
    input  logic             a_wr,
    input  logic             a_st,
    input  logic             a_fault,
    input  logic             b_vld,
    input  logic             b_is_br,
    input  logic             b_is_c,
    input  logic [OFF_W-1:0] b_off,
    input  logic             b_wr,
    input  logic             b_st,
    input  logic             b_fault,
    input  logic             br_taken,
    output logic             l0_wb_en,
    output logic             l0_st_en,
    output logic             l0_exc,
    output logic             l1_wb_en,
    output logic             l1_st_en,
    output logic             l1_exc,
    output logic             l1_cancel
);
    insn_t  ia, ib;
    logic   paired;
    stage_t in_stage, fin;

    always_comb begin
        ia = '{vld: a_vld, is_br: a_is_br, is_c: a_is_c, off: a_off,
               wr: a_wr, st: a_st, fault: a_fault};
        ib = '{vld: b_vld, is_br: b_is_br, is_c: b_is_c, off: b_off,
               wr: b_wr, st: b_st, fault: b_fault};
        in_stage.l0     = to_slot(ia);
        in_stage.l1     = to_slot(ib);
        in_stage.paired = paired;
    end

    ssq_pair_detect u_detect (.a(ia), .b(ib), .paired(paired));

    ssq_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst(rst), .stall(stall), .flush(flush),
        .in_stage(in_stage), .fin(fin)
    );

    ssq_commit_gate u_gate (
        .fin(fin), .stall(stall), .flush(flush), .br_taken(br_taken),
        .l0_wb_en(l0_wb_en), .l0_st_en(l0_st_en), .l0_exc(l0_exc),
        .l1_wb_en(l1_wb_en), .l1_st_en(l1_st_en), .l1_exc(l1_exc),
        .l1_cancel(l1_cancel)
    );

    // R4: a cancelled lane 1 shows no effect
    a_r4_cancel_quiet: assert property (@(posedge clk) disable iff (rst)
        l1_cancel |-> (!l1_wb_en && !l1_st_en && !l1_exc));
    // R7: nothing commits during a stall
    a_r7_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        stall |-> !(l0_wb_en || l0_st_en || l0_exc || l1_wb_en || l1_st_en || l1_exc || l1_cancel));
    // R8: nothing commits during a flush
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        flush |-> !(l0_wb_en || l0_st_en || l0_exc || l1_wb_en || l1_st_en || l1_exc || l1_cancel));
    // R2: cancellation needs a taken outcome
    a_r2_cancel_needs_taken: assert property (@(posedge clk) disable iff (rst)
        l1_cancel |-> br_taken);
endmodule

// File: tb/short_branch_squash_bench.sv
module short_branch_squash_bench;
    import ssq_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;

    logic clk = 0, rst = 1, stall = 0, flush = 0, br_taken = 0;
    logic a_vld = 0, a_is_br = 0, a_is_c = 0, a_wr = 0, a_st = 0, a_fault = 0;
    logic b_vld = 0, b_is_br = 0, b_is_c = 0, b_wr = 0, b_st = 0, b_fault = 0;
    logic [OFF_W-1:0] a_off = '0, b_off = '0;
    logic l0_wb_en, l0_st_en, l0_exc, l1_wb_en, l1_st_en, l1_exc, l1_cancel;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    short_branch_squash #(.DEPTH(DEPTH)) u_short_branch_squash (.*);

    // output order: l0 wb,st,exc | l1 wb,st,exc | cancel
    function automatic logic [6:0] outs();
        return {l0_wb_en, l0_st_en, l0_exc, l1_wb_en, l1_st_en, l1_exc, l1_cancel};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, outs(), exp);
        end
    endtask

    // drive a group on the negedge; {vld,is_br,is_c,wr,st,fault}
    task automatic drive(input logic [5:0] a, input int off, input logic [5:0] b);
        {a_vld, a_is_br, a_is_c, a_wr, a_st, a_fault} = a;
        a_off = OFF_W'(off);
        {b_vld, b_is_br, b_is_c, b_wr, b_st, b_fault} = b;
    endtask

    task automatic idle();
        drive('0, 0, '0);
    endtask

    // issue one group and wait until it sits in the final stage
    task automatic issue(input logic [5:0] a, input int off, input logic [5:0] b);
        @(negedge clk); drive(a, off, b);
        @(negedge clk); idle();
        repeat (DEPTH-1) @(negedge clk);
    endtask

    task automatic final_check(input string req, input logic taken, input logic [6:0] exp);
        br_taken = taken; #1;
        chk(req, exp);
        @(negedge clk); br_taken = 0; #1;
        chk({req, " drained"}, 7'b0);
    endtask

    task automatic t_reset();
        #1 chk("R9 reset", 7'b0);
    endtask

    task automatic t_pair_taken();
        // branch 4B off 8, lane1 4B writes reg + store + fault
        issue(6'b110_000, 8, 6'b100_111);
        final_check("R4 taken cancels", 1'b1, 7'b000_000_1);
    endtask

    task automatic t_pair_not_taken();
        issue(6'b110_000, 8, 6'b100_110);
        final_check("R5 not taken commits", 1'b0, 7'b000_110_0);
    endtask

    task automatic t_compressed();
        issue(6'b111_000, 4, 6'b101_100);   // 2+2
        final_check("R1 2+2 pair", 1'b1, 7'b000_000_1);
        issue(6'b110_000, 6, 6'b101_010);   // 4+2
        final_check("R1 4+2 pair", 1'b1, 7'b000_000_1);
    endtask

    task automatic t_mismatch();
        issue(6'b110_000, 8, 6'b101_100);   // needs 6
        final_check("R2 off mismatch", 1'b1, 7'b000_100_0);
        issue(6'b110_000, 12, 6'b100_100);
        final_check("R2 off too far", 1'b1, 7'b000_100_0);
        issue(6'b110_000, 8, 6'b110_100);   // lane1 is a branch
        final_check("R2 lane1 branch", 1'b1, 7'b000_100_0);
        issue(6'b100_100, 8, 6'b100_100);   // lane0 not a branch
        final_check("R2 lane0 plain", 1'b1, 7'b100_100_0);
    endtask

    task automatic t_lane0();
        issue(6'b110_111, 8, 6'b100_100);
        final_check("R6 lane0 unaffected", 1'b1, 7'b111_000_1);
    endtask

    task automatic t_timing();
        @(negedge clk); drive(6'b110_000, 8, 6'b100_100);
        @(negedge clk); idle();
        repeat (DEPTH-2) @(negedge clk);
        br_taken = 0; #1;
        chk("R3 not early", 7'b0);
        @(negedge clk); #1;
        chk("R3 on time", 7'b000_100_0);
        @(negedge clk); #1;
        chk("R3 single", 7'b0);
    endtask

    task automatic t_stall();
        @(negedge clk); drive(6'b110_000, 8, 6'b100_110);
        @(negedge clk); idle(); stall = 1;
        repeat (5) @(negedge clk);
        #1 chk("R7 stall quiet", 7'b0);
        stall = 0;
        repeat (DEPTH-1) @(negedge clk);
        final_check("R7 pair kept", 1'b1, 7'b000_000_1);
        issue(6'b110_000, 8, 6'b100_110);
        stall = 1; br_taken = 0; #1;
        chk("R7 stall at final", 7'b0);
        @(negedge clk); stall = 0;
        final_check("R7 resume final", 1'b0, 7'b000_110_0);
    endtask

    task automatic t_flush();
        @(negedge clk); drive(6'b100_100, 0, 6'b100_100);
        @(negedge clk); idle(); flush = 1;
        @(negedge clk); flush = 0;
        repeat (DEPTH) begin
            @(negedge clk); #1 chk("R8 flushed gone", 7'b0);
        end
        issue(6'b100_100, 0, 6'b100_100);
        flush = 1; stall = 1; #1;
        chk("R8 flush at final", 7'b0);
        @(negedge clk); flush = 0; stall = 0; #1;
        chk("R8 flush beats stall", 7'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        t_reset();
        t_pair_taken();
        t_pair_not_taken();
        t_compressed();
        t_mismatch();
        t_lane0();
        t_timing();
        t_stall();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule